// File: doc/BRIEF.md
# Single-Cycle RV32I Integer Core

This block executes a subset of the 32-bit RISC-V base integer instruction set and retires one instruction on every rising clock edge. It contains the program counter, a 32-entry register file, an opcode decoder, ALU function selection, an immediate builder, the ALU, and the multiplexers that choose the ALU operand and the register writeback value. The supported instructions are register-register add and sub, the immediate ALU operations (addi, slti, sltiu, xori, ori, andi, slli, srli, srai), word loads and stores, and the four conditional branches beq, bne, blt and bge.

The core uses one dual-port, word-addressed memory of 1024 words that holds both code and data. The fetch port is clocked on the rising edge. To make this work, the core presents the word address of the next instruction, so the instruction word for the new PC is present just after the edge. The data port is clocked on the falling edge. A load address computed in the first half of the cycle returns its data before the next rising edge, and that edge then writes the value into the register file. Register reads are combinational. A store is committed by the memory on the falling edge.

Top module: `rv_single_core`

## Requirements
- R1: When no branch is taken, the PC advances by 4 on every rising edge after reset, so `ia_addr` steps by one word per cycle.
- R2: While `rst` is high, the PC is held at 0, `ia_addr` is 0, `db_we` is 0, and every register is cleared. After reset, a register that was never written reads as 0.
- R3: The memory word address is byte address bits [11:2], so byte addresses 4096 apart reach the same word. This applies to both fetch and data accesses.
- R4: R-type (opcode 0110011) with funct3 000 adds when funct7 is 0000000 and subtracts when funct7 is 0100000.
- R5: I-type ALU operations (opcode 0010011) select the function with funct3: 000 add, 010 signed set-less-than, 011 unsigned set-less-than, 100 xor, 110 or, 111 and, 001 shift left, and 101 shift right. For 101, instruction bit 30 picks arithmetic (1) or logical (0). The 12-bit immediate is sign-extended.
- R6: lw (opcode 0000011, funct3 010) and sw (opcode 0100011, funct3 010) address rs1 plus a sign-extended 12-bit offset. A loaded value can be used by the very next instruction. A load and a store are never requested in the same cycle.
- R7: Branches (opcode 1100011) use funct3 000 beq, 001 bne, 100 blt and 101 bge, and compare as signed. A taken branch moves the PC to PC plus the sign-extended B-immediate, and backward targets are allowed.
- R8: Register x0 always reads as 0. Writes to x0 are dropped.
- R9: An unsupported opcode writes no register and drives no store.
- R10: `ia_addr` carries the word address of the instruction that executes in the next cycle, including a taken-branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC and registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ia_addr | output | 10 | Fetch port word address of the next instruction |
| ia_rdata | input | 32 | Instruction word registered by the memory on the rising edge |
| db_addr | output | 10 | Data port word address (ALU result bits [11:2]) |
| db_we | output | 1 | Store request, committed by the memory on the falling edge |
| db_re | output | 1 | Load request |
| db_wdata | output | 32 | Store data (rs2 value) |
| db_rdata | input | 32 | Load data registered by the memory on the falling edge |

## Verification
The hardest case to reach is a load whose result feeds the next instruction. Inside one cycle, the data travels from the falling-edge read, through the rising-edge writeback, and into a combinational register read. The stimulus preloads a memory word, loads it, adds to it in the next instruction, and stores the sum, so that any half-cycle slip corrupts the stored word. Address wrap is driven by building a base register of 4096 with a shift, storing through it, and reading the word back at the low address. Reset clearing is shown by running a second program that stores a register set only by an earlier program.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;

   typedef enum logic [1:0] {
      AOP_MEM = 2'b00,
      AOP_BR  = 2'b01,
      AOP_FN  = 2'b10,
      AOP_RSV = 2'b11
   } aop_e;

   typedef enum logic [3:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
      ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT, ALU_SLTU
   } alu_fn_e;

   typedef enum logic [1:0] {
      IMM_I = 2'd0,
      IMM_S = 2'd1,
      IMM_B = 2'd2
   } imm_kind_e;

   typedef struct packed {
      logic alu_src;
      logic mem_to_reg;
      logic reg_write;
      logic mem_read;
      logic mem_write;
      logic branch;
      aop_e alu_op;
   } ctl_t;

endpackage

// File: rtl/rvc_control.sv
module rvc_control
   import rvc_pkg::*;
(
   input  logic [6:0] opcode,
   output ctl_t       ctl,
   output imm_kind_e  imm_kind
);

   always_comb begin
      ctl      = '{alu_src: 1'b0, mem_to_reg: 1'b0, reg_write: 1'b0,
                   mem_read: 1'b0, mem_write: 1'b0, branch: 1'b0,
                   alu_op: AOP_MEM};
      imm_kind = IMM_I;
      case (opcode)
         OPC_REG: begin
            ctl.reg_write = 1'b1;
            ctl.mem_write = 1'b0;
            ctl.alu_op    = AOP_FN;
         end
         OPC_IMM: begin
            ctl.alu_src   = 1'b1;
            ctl.reg_write = 1'b1;
            ctl.mem_write = 1'b0;
            ctl.alu_op    = AOP_FN;
         end
         OPC_LOAD: begin
            ctl.alu_src    = 1'b1;
            ctl.mem_to_reg = 1'b1;
            ctl.reg_write  = 1'b1;
            ctl.mem_read   = 1'b1;
            ctl.mem_write  = 1'b0;
            ctl.alu_op     = AOP_MEM;
         end
         OPC_STORE: begin
            ctl.alu_src   = 1'b1;
            ctl.reg_write = 1'b0;
            ctl.mem_write = 1'b1;
            ctl.alu_op    = AOP_MEM;
            imm_kind      = IMM_S;
         end
         OPC_BRANCH: begin
            ctl.reg_write = 1'b0;
            ctl.mem_write = 1'b0;
            ctl.branch    = 1'b1;
            ctl.alu_op    = AOP_BR;
            imm_kind      = IMM_B;
         end
         default: begin
            ctl.reg_write = 1'b0;
            ctl.mem_write = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/rvc_alu_ctl.sv
module rvc_alu_ctl
   import rvc_pkg::*;
(
   input  aop_e       alu_op,
   input  logic [2:0] funct3,
   input  logic       alt_bit,
   input  logic       is_reg,
   output alu_fn_e    fn
);

   always_comb begin
      fn = ALU_ADD;
      case (alu_op)
         AOP_MEM: fn = ALU_ADD;
         AOP_BR:  fn = ALU_SUB;
         AOP_FN: begin
            case (funct3)
               3'b000: fn = (is_reg && alt_bit) ? ALU_SUB : ALU_ADD;
               3'b001: fn = ALU_SLL;
               3'b010: fn = ALU_SLT;
               3'b011: fn = ALU_SLTU;
               3'b100: fn = ALU_XOR;
               3'b101: fn = alt_bit ? ALU_SRA : ALU_SRL;
               3'b110: fn = ALU_OR;
               default: fn = ALU_AND;
            endcase
         end
         default: fn = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/rvc_immgen.sv
module rvc_immgen
   import rvc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [11:0]     f_hi,
   input  logic [4:0]      f_lo,
   input  imm_kind_e       kind,
   output logic [XLEN-1:0] imm
);

   localparam int unsigned EXT_I = XLEN - 12;
   localparam int unsigned EXT_B = XLEN - 13;

   logic sgn;
   assign sgn = f_hi[11];

   always_comb begin
      case (kind)
         IMM_S:   imm = {{EXT_I{sgn}}, f_hi[11:5], f_lo};
         IMM_B:   imm = {{EXT_B{sgn}}, sgn, f_lo[0], f_hi[10:5], f_lo[4:1], 1'b0};
         default: imm = {{EXT_I{sgn}}, f_hi};
      endcase
   end

endmodule

// File: rtl/rvc_alu.sv
module rvc_alu
   import rvc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_fn_e         fn,
   output logic [XLEN-1:0] y,
   output logic            zero,
   output logic            lt
);

   localparam int unsigned SHW = $clog2(XLEN);

   logic [XLEN-1:0] diff;
   logic [SHW-1:0]  sh;

   assign diff = a - b;
   assign sh   = b[SHW-1:0];
   assign zero = (diff == '0);
   assign lt   = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : diff[XLEN-1];

   always_comb begin
      case (fn)
         ALU_SUB:  y = diff;
         ALU_AND:  y = a & b;
         ALU_OR:   y = a | b;
         ALU_XOR:  y = a ^ b;
         ALU_SLL:  y = a << sh;
         ALU_SRL:  y = a >> sh;
         ALU_SRA:  y = $unsigned($signed(a) >>> sh);
         ALU_SLT:  y = {{(XLEN-1){1'b0}}, lt};
         ALU_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
         default:  y = a + b;
      endcase
   end

endmodule

// File: rtl/rvc_regfile.sv
module rvc_regfile #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned NREGS   = 32,
   parameter int unsigned NREAD   = 2
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NREAD-1:0][$clog2(NREGS)-1:0] ra,
   output logic [NREAD-1:0][XLEN-1:0]       rd,
   input  logic                             we,
   input  logic [$clog2(NREGS)-1:0]         wa,
   input  logic [XLEN-1:0]                  wd
);

   localparam int unsigned AW = $clog2(NREGS);

   if (NREGS != (1 << AW)) begin : g_bad_depth
      $error("rvc_regfile: NREGS must be a power of two");
   end

   logic [XLEN-1:0] regs [NREGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (we && (wa != '0)) begin
         regs[wa] <= wd;
      end
   end

   for (genvar p = 0; p < NREAD; p++) begin : g_rd
      assign rd[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
   end

endmodule

// File: rtl/rv_single_core.sv
module rv_single_core
   import rvc_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned NREGS   = 32,
   parameter int unsigned MEM_AW  = 10
) (
   input  logic              clk,
   input  logic              rst,
   output logic [MEM_AW-1:0] ia_addr,
   input  logic [XLEN-1:0]   ia_rdata,
   output logic [MEM_AW-1:0] db_addr,
   output logic              db_we,
   output logic              db_re,
   output logic [XLEN-1:0]   db_wdata,
   input  logic [XLEN-1:0]   db_rdata
);

   localparam int unsigned RAW    = $clog2(NREGS);
   localparam int unsigned BYTE_LO = 2;
   localparam int unsigned BYTE_HI = BYTE_LO + MEM_AW - 1;

   if (XLEN != 32) begin : g_bad_xlen
      $error("rv_single_core: only XLEN 32 is supported");
   end
   if (RAW > 5 || NREGS < 2) begin : g_bad_regs
      $error("rv_single_core: NREGS must be between 2 and 32");
   end
   if (BYTE_HI >= XLEN) begin : g_bad_aw
      $error("rv_single_core: MEM_AW too wide for XLEN");
   end

   logic [XLEN-1:0] pc_q, pc_plus4, br_target, pc_next;
   logic [XLEN-1:0] imm_val, alu_b, alu_y, wb_data;
   logic [1:0][RAW-1:0]  rf_ra;
   logic [1:0][XLEN-1:0] rf_rd;
   ctl_t      ctl;
   imm_kind_e imm_kind;
   alu_fn_e   alu_fn;
   logic      alu_zero, alu_lt, br_cond, br_taken;

   // control
   rvc_control u_ctl (
      .opcode   (ia_rdata[6:0]),
      .ctl      (ctl),
      .imm_kind (imm_kind)
   );

   rvc_alu_ctl u_aluctl (
      .alu_op  (ctl.alu_op),
      .funct3  (ia_rdata[14:12]),
      .alt_bit (ia_rdata[30]),
      .is_reg  (ia_rdata[5]),
      .fn      (alu_fn)
   );

   rvc_immgen #(.XLEN(XLEN)) u_imm (
      .f_hi (ia_rdata[31:20]),
      .f_lo (ia_rdata[11:7]),
      .kind (imm_kind),
      .imm  (imm_val)
   );

   // register file
   assign rf_ra[0] = ia_rdata[15 +: RAW];
   assign rf_ra[1] = ia_rdata[20 +: RAW];

   rvc_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NREAD(2)) u_rf (
      .clk (clk),
      .rst (rst),
      .ra  (rf_ra),
      .rd  (rf_rd),
      .we  (ctl.reg_write),
      .wa  (ia_rdata[7 +: RAW]),
      .wd  (wb_data)
   );

   // execute
   assign alu_b = ctl.alu_src ? imm_val : rf_rd[1];

   rvc_alu #(.XLEN(XLEN)) u_alu (
      .a    (rf_rd[0]),
      .b    (alu_b),
      .fn   (alu_fn),
      .y    (alu_y),
      .zero (alu_zero),
      .lt   (alu_lt)
   );

   always_comb begin
      case (ia_rdata[14:12])
         3'b000:  br_cond = alu_zero;
         3'b001:  br_cond = !alu_zero;
         3'b100:  br_cond = alu_lt;
         3'b101:  br_cond = !alu_lt;
         default: br_cond = 1'b0;
      endcase
   end

   assign br_taken = ctl.branch && br_cond;

   // memory and writeback
   assign db_addr  = alu_y[BYTE_HI:BYTE_LO];
   assign db_we    = ctl.mem_write && !rst;
   assign db_re    = ctl.mem_read && !rst;
   assign db_wdata = rf_rd[1];
   assign wb_data  = ctl.mem_to_reg ? db_rdata : alu_y;

   // program counter
   assign pc_plus4  = pc_q + XLEN'(4);
   assign br_target = pc_q + imm_val;
   assign pc_next   = br_taken ? br_target : pc_plus4;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   assign ia_addr = rst ? '0 : pc_next[BYTE_HI:BYTE_LO];

endmodule

// File: rtl/rvc_core_checks.sv
module rvc_core_checks #(
   parameter int unsigned XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] pc,
   input logic            taken,
   input logic [XLEN-1:0] imm,
   input logic            db_we,
   input logic            db_re
);

   a_r1_pc_step: assert property (@(posedge clk) disable iff (rst)
      !taken |=> pc == $past(pc) + XLEN'(4))
      else $error("R1: PC did not advance by 4");

   a_r1_pc_aligned: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00)
      else $error("R1: PC not word aligned");

   a_r2_reset_pc: assert property (@(posedge clk)
      rst |=> pc == '0)
      else $error("R2: PC not cleared by reset");

   a_r7_branch_target: assert property (@(posedge clk) disable iff (rst)
      taken |=> pc == $past(pc) + $past(imm))
      else $error("R7: taken branch went to wrong target");

   a_r6_one_access: assert property (@(posedge clk) disable iff (rst)
      !(db_we && db_re))
      else $error("R6: load and store requested together");

endmodule

bind rv_single_core rvc_core_checks #(.XLEN(XLEN)) u_checks (
   .clk   (clk),
   .rst   (rst),
   .pc    (pc_q),
   .taken (br_taken),
   .imm   (imm_val),
   .db_we (db_we),
   .db_re (db_re)
);

// File: tb/rv_single_core_test.sv
module rv_single_core_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [9:0]  ia_addr, db_addr;
   logic [31:0] ia_rdata, db_wdata, db_rdata;
   logic        db_we, db_re;

   logic [31:0] mem [1024];
   logic        ld_en = 1'b0;
   int          ld_a = 0;
   logic [31:0] ld_d = '0;
   int          p = 0;
   int          checks = 0;
   int          errors = 0;

   always #2 clk = ~clk;

   rv_single_core uut (
      .clk(clk), .rst(rst),
      .ia_addr(ia_addr), .ia_rdata(ia_rdata),
      .db_addr(db_addr), .db_we(db_we), .db_re(db_re),
      .db_wdata(db_wdata), .db_rdata(db_rdata)
   );

   // memory model: fetch on rising edge, data port on falling edge
   always @(posedge clk) ia_rdata <= mem[ia_addr];
   always @(negedge clk) begin
      if (ld_en) mem[ld_a] <= ld_d;
      else begin
         db_rdata <= mem[db_addr];
         if (db_we === 1'b1) mem[db_addr] <= db_wdata;
      end
   end

   // encoders
   function automatic logic [31:0] e_r(input logic [6:0] f7, input int rs2, rs1,
                                       input logic [2:0] f3, input int rd);
      return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
   endfunction
   function automatic logic [31:0] e_i(input int imm, rs1, input logic [2:0] f3,
                                       input int rd, input logic [6:0] op);
      logic [11:0] v = 12'(imm);
      return {v, 5'(rs1), f3, 5'(rd), op};
   endfunction
   function automatic logic [31:0] e_s(input int imm, rs2, rs1);
      logic [11:0] v = 12'(imm);
      return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] e_b(input int off, rs1, rs2, input logic [2:0] f3);
      logic [12:0] v = 13'(off);
      return {v[12], v[10:5], 5'(rs2), 5'(rs1), f3, v[4:1], v[11], 7'b1100011};
   endfunction
   function automatic logic [31:0] addi(input int rd, rs1, imm);
      return e_i(imm, rs1, 3'b000, rd, 7'b0010011);
   endfunction
   localparam logic [31:0] HALT = 32'h0000_0063; // beq x0,x0,0

   task automatic poke(input int a, input logic [31:0] d);
      @(posedge clk);
      ld_en = 1'b1; ld_a = a; ld_d = d;
      @(negedge clk);
   endtask

   task automatic emit(input logic [31:0] w);
      poke(p, w);
      p++;
   endtask

   task automatic fresh();
      rst = 1'b1;
      p = 0;
      for (int i = 0; i < 1024; i++) poke(i, 32'h0000_0013);
   endtask

   task automatic launch();
      @(posedge clk); ld_en = 1'b0;
      @(posedge clk);
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk); #1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic t_reset_and_fetch();
      fresh();
      emit(addi(0, 0, 0)); emit(addi(0, 0, 0)); emit(addi(0, 0, 0));
      emit(e_b(-12, 0, 0, 3'b000));
      @(posedge clk); ld_en = 1'b0;
      @(negedge clk); #1;
      chk("R2", "fetch addr in reset", 32'(ia_addr), 32'd0);
      chk("R2", "no store in reset", 32'(db_we), 32'd0);
      @(posedge clk);
      @(negedge clk); rst = 1'b0; #1;
      chk("R10", "next fetch after reset", 32'(ia_addr), 32'd1);
      @(negedge clk); #1;
      chk("R1", "pc step", 32'(ia_addr), 32'd2);
      @(negedge clk); #1;
      chk("R1", "pc step", 32'(ia_addr), 32'd3);
      @(negedge clk); #1;
      chk("R10", "backward branch fetch", 32'(ia_addr), 32'd0);
   endtask

   task automatic t_rtype();
      fresh();
      emit(addi(1, 0, 7)); emit(addi(2, 0, -3));
      emit(e_r(7'h00, 2, 1, 3'b000, 3));
      emit(e_r(7'h20, 2, 1, 3'b000, 4));
      emit(e_r(7'h20, 1, 2, 3'b000, 5));
      emit(e_s(256, 3, 0)); emit(e_s(260, 4, 0)); emit(e_s(264, 5, 0));
      emit(HALT);
      launch(); run(20);
      chk("R4", "add", mem[64], 32'd4);
      chk("R4", "sub", mem[65], 32'd10);
      chk("R4", "sub negative", mem[66], 32'hFFFF_FFF6);
   endtask

   task automatic t_itype();
      fresh();
      emit(addi(1, 0, -16));
      emit(e_i(255, 1, 3'b111, 2, 7'b0010011));
      emit(e_i(5, 1, 3'b110, 3, 7'b0010011));
      emit(e_i(-1, 1, 3'b100, 4, 7'b0010011));
      emit(e_i(0, 1, 3'b010, 5, 7'b0010011));
      emit(e_i(1, 1, 3'b011, 6, 7'b0010011));
      emit(e_i(4, 1, 3'b001, 7, 7'b0010011));
      emit(e_i(28, 1, 3'b101, 8, 7'b0010011));
      emit(e_i(32'h402, 1, 3'b101, 9, 7'b0010011));
      for (int k = 0; k < 8; k++) emit(e_s(256 + 4 * k, k + 2, 0));
      emit(HALT);
      launch(); run(30);
      chk("R5", "andi", mem[64], 32'h0000_00F0);
      chk("R5", "ori", mem[65], 32'hFFFF_FFF5);
      chk("R5", "xori", mem[66], 32'h0000_000F);
      chk("R5", "slti", mem[67], 32'd1);
      chk("R5", "sltiu", mem[68], 32'd0);
      chk("R5", "slli", mem[69], 32'hFFFF_FF00);
      chk("R5", "srli", mem[70], 32'h0000_000F);
      chk("R5", "srai", mem[71], 32'hFFFF_FFFC);
   endtask

   task automatic t_loadstore();
      fresh();
      poke(200, 32'h1234_5678);
      emit(e_i(800, 0, 3'b010, 5, 7'b0000011));
      emit(addi(6, 5, 1));
      emit(e_s(804, 6, 0));
      emit(addi(7, 0, 900));
      emit(e_i(-100, 7, 3'b010, 8, 7'b0000011));
      emit(e_s(-92, 8, 7));
      emit(HALT);
      launch(); run(20);
      chk("R6", "load then use", mem[201], 32'h1234_5679);
      chk("R6", "negative offsets", mem[202], 32'h1234_5678);
   endtask

   task automatic t_x0();
      fresh();
      emit(addi(0, 0, 5));
      emit(e_r(7'h00, 0, 0, 3'b000, 9));
      emit(e_s(272, 0, 0)); emit(e_s(276, 9, 0));
      emit(HALT);
      poke(68, 32'hAAAA_AAAA); poke(69, 32'hBBBB_BBBB);
      launch(); run(15);
      chk("R8", "x0 read after write", mem[68], 32'd0);
      chk("R8", "x0 sum", mem[69], 32'd0);
   endtask

   task automatic t_branches();
      logic [31:0] exp [9];
      logic [2:0]  f3 [9];
      int          a1 [9];
      int          a2 [9];
      f3 = '{3'b000, 3'b000, 3'b001, 3'b001, 3'b100, 3'b100, 3'b101, 3'b101, 3'b101};
      a1 = '{2, 1, 1, 2, 1, 2, 2, 2, 1};
      a2 = '{3, 2, 2, 3, 2, 1, 1, 3, 2};
      exp = '{1, 0, 1, 0, 1, 0, 1, 1, 0};
      fresh();
      emit(addi(1, 0, -1)); emit(addi(2, 0, 1)); emit(addi(3, 0, 1));
      for (int k = 0; k < 9; k++) begin
         emit(addi(20, 0, 1));
         emit(e_b(8, a1[k], a2[k], f3[k]));
         emit(addi(20, 0, 0));
         emit(e_s(320 + 4 * k, 20, 0));
      end
      emit(addi(11, 0, 3)); emit(addi(12, 0, 0));
      emit(addi(12, 12, 5)); emit(addi(11, 11, -1));
      emit(e_b(-8, 11, 0, 3'b001));
      emit(e_s(360, 12, 0));
      emit(HALT);
      launch(); run(70);
      for (int k = 0; k < 9; k++)
         chk("R7", $sformatf("branch case %0d", k), mem[80 + k], exp[k]);
      chk("R7", "backward loop", mem[90], 32'd15);
   endtask

   task automatic t_reset_clears();
      fresh();
      emit(addi(1, 0, 55)); emit(HALT);
      launch(); run(6);
      fresh();
      emit(e_s(448, 1, 0)); emit(HALT);
      poke(112, 32'hCCCC_CCCC);
      launch(); run(6);
      chk("R2", "register cleared by reset", mem[112], 32'd0);
   endtask

   task automatic t_wrap();
      fresh();
      emit(addi(2, 0, 77)); emit(addi(1, 0, 1));
      emit(e_i(12, 1, 3'b001, 1, 7'b0010011));
      emit(e_s(320, 2, 1));
      emit(e_i(320, 0, 3'b010, 3, 7'b0000011));
      emit(e_s(324, 3, 0));
      emit(HALT);
      launch(); run(15);
      chk("R3", "wrapped store", mem[80], 32'd77);
      chk("R3", "read back low alias", mem[81], 32'd77);
   endtask

   task automatic t_unsupported();
      fresh();
      emit(addi(3, 0, 5));
      emit(32'h0000_01FF);
      emit(32'h1234_51B7);
      emit(e_s(384, 3, 0));
      emit(HALT);
      launch();
      @(negedge clk); #1;
      chk("R9", "no store for unknown opcode", 32'(db_we), 32'd0);
      run(10);
      chk("R9", "register untouched", mem[96], 32'd5);
   endtask

   initial begin
      #(4 * 190000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      t_reset_and_fetch();
      t_rtype();
      t_itype();
      t_loadstore();
      t_x0();
      t_branches();
      t_reset_clears();
      t_wrap();
      t_unsupported();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule